// File: doc/BRIEF.md
# Pulse-Latching Interrupt Hub

This block gathers 64 interrupt request lines behind a 32-bit APB slave port and presents them to a processor as one interrupt output. Every request line first passes through a two-flop synchronizer. When the `PULSE_MODE` parameter is set, a rising edge on a synchronized request is caught in a flag bit that software can clear. When the parameter is clear, the synchronized level is used directly.

Each source has an enable bit. The AND of enable and request is the pending state of that source, read as two 32-bit words. The interrupt output is the registered OR of all pending bits, gated by a global on/off bit. The block also holds a 64-slot byte table that software fills with source channel numbers and reads back. It applies no meaning of its own to that table.

The register layout is fixed by software convention. Each flag word lies 8 bytes below its enable word. Low words cover sources 0 to 31 and high words cover sources 32 to 63, with bit n of a word standing for source (32*word + n).

Top module: `pulse_irq_hub`

## Requirements
- R1: After reset, these all read 0: the control word (0x00), both enable words (0x10 low, 0x28 high), both flag words (0x08 low, 0x20 high), both pending words (0x14 low, 0x2C high) and every slot-table word. `irq_o` is 0 after reset.
- R2: The control word stores only bit 31, the global enable, and reads 0 in bits 30:0. Both enable words store and read back any 32-bit value.
- R3: Pending low (0x14) and pending high (0x2C) read as the bitwise AND of the matching enable word and the effective request word. A source whose enable bit is 0 reads 0.
- R4: With `PULSE_MODE`=1, a request that stays high for at least one clock sets its flag bit, and the bit stays set after the input returns low. The flag bit is the effective request.
- R5: A write to a flag word clears each bit written as 0. Bits written as 1 keep their value.
- R6: When a synchronized rising edge and a clear-by-write hit the same flag bit in the same cycle, the bit ends up set.
- R7: With `PULSE_MODE`=0, the effective request is the synchronized input level, and both flag words read 0.
- R8: `irq_o` is the OR of all pending bits, qualified by control bit 31. It is registered, so it changes on the clock edge after the pending state or the control bit changes.
- R9: When control bit 31 is 0, `irq_o` is 0 from the following cycle on, whatever is pending.
- R10: The pending words are read-only. Writes to them change no enable, flag or control state.
- R11: Reads of unmapped offsets return 0. `pready` is always 1 and `pslverr` is always 0.
- R12: The slot table spans offsets 0x40 to 0x7F as 16 words of four byte slots. Each word stores and reads back any 32-bit value, such as base index N in every byte plus 3, 2, 1, 0 in byte lanes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_src_i | input | 64 | Interrupt request lines |
| irq_o | output | 1 | Registered interrupt to the processor |

## Verification
The hardest case to reach from the ports is a software clear that lands in the same cycle as a newly synchronized rising edge. The synchronizer delay hides the exact cycle in which the edge becomes visible. The stimulus raises a request on a falling clock edge and starts an APB write of zeros to the flag word on the next falling edge. With this timing, the access-phase edge of the write coincides with the synchronizer's edge-detect cycle. A flag bit set earlier is cleared by the same write, which shows that the clear itself took effect.

// File: rtl/pih_pkg.sv
package pih_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NSRC     = 64;
  localparam int unsigned NWORDS   = NSRC / WORD_W;
  localparam int unsigned GEN_BIT  = 31;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_FLAG_LO = 8'h08;
  localparam logic [7:0] OFS_EN_LO   = 8'h10;
  localparam logic [7:0] OFS_PEND_LO = 8'h14;
  localparam logic [7:0] OFS_FLAG_HI = 8'h20;
  localparam logic [7:0] OFS_EN_HI   = 8'h28;
  localparam logic [7:0] OFS_PEND_HI = 8'h2C;
  localparam logic [7:0] OFS_TBL_LO  = 8'h40;
  localparam logic [7:0] OFS_TBL_HI  = 8'h7F;

  // pending = enable gated request
  function automatic logic [WORD_W-1:0] pend_word(input logic [WORD_W-1:0] en,
                                                  input logic [WORD_W-1:0] req);
    return en & req;
  endfunction

  // next flag value: kept bits survive, new edges always set
  function automatic logic [NSRC-1:0] flag_next(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] keep,
                                                input logic [NSRC-1:0] rise);
    return (cur & keep) | rise;
  endfunction

  function automatic logic in_table(input logic [7:0] a);
    return (a >= OFS_TBL_LO) && (a <= OFS_TBL_HI);
  endfunction
endpackage

// File: rtl/pih_sync.sv
module pih_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pih_flags.sv
module pih_flags
  import pih_pkg::*;
#(
  parameter bit PULSE_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_s_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [NSRC-1:0]   req_eff_o,
  output logic [NSRC-1:0]   flag_o
);
  if (PULSE_MODE) begin : g_pulse
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] rise_w;
    logic [NSRC-1:0] keep_w;

    assign rise_w = req_s_i & ~prev_q;
    assign keep_w = {(wr_hi_i ? wdata_i : {WORD_W{1'b1}}),
                     (wr_lo_i ? wdata_i : {WORD_W{1'b1}})};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        flag_q <= '0;
      end else begin
        prev_q <= req_s_i;
        flag_q <= flag_next(flag_q, keep_w, rise_w);
      end
    end

    assign req_eff_o = flag_q;
    assign flag_o    = flag_q;

    // R4 R6
    // every detected edge leaves its flag set, even under a clearing write
    rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_w != '0) |=> ((flag_q & $past(rise_w)) == $past(rise_w)));

    // R4
    // a flag never rises without an edge
    no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(rise_w)) == '0));

    // R5
    // without any flag write, set flags stay set
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo_i && !wr_hi_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  end else begin : g_level
    assign req_eff_o = req_s_i;
    assign flag_o    = '0;
  end
endmodule

// File: rtl/pih_slots.sv
module pih_slots #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] slot_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) slot_q[i] <= '0;
    end else if (we_i) begin
      slot_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[idx_i];

  // R12
  tbl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (slot_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/pulse_irq_hub.sv
module pulse_irq_hub
  import pih_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          PULSE_MODE  = 1'b1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NSRC-1:0]   irq_src_i,
  output logic              irq_o
);
  localparam int unsigned TBL_WORDS = NSRC / 4;
  localparam int unsigned TIDX_W    = $clog2(TBL_WORDS);

  logic [7:0]        a8;
  logic              wr_go;
  logic              hit_ctrl, hit_en_lo, hit_en_hi, hit_flag_lo, hit_flag_hi;
  logic              hit_pend_lo, hit_pend_hi, hit_tbl;
  logic              gen_q;
  logic [NSRC-1:0]   en_q;
  logic [NSRC-1:0]   req_s_w;
  logic [NSRC-1:0]   req_eff_w;
  logic [NSRC-1:0]   flag_w;
  logic [NSRC-1:0]   pend_w;
  logic              irq_q;
  logic [31:0]       tbl_rd_w;
  logic [31:0]       rd_mux;

  assign a8     = 8'(paddr);
  assign wr_go  = psel & penable & pwrite;

  assign hit_ctrl    = (a8 == OFS_CTRL);
  assign hit_en_lo   = (a8 == OFS_EN_LO);
  assign hit_en_hi   = (a8 == OFS_EN_HI);
  assign hit_flag_lo = (a8 == OFS_FLAG_LO);
  assign hit_flag_hi = (a8 == OFS_FLAG_HI);
  assign hit_pend_lo = (a8 == OFS_PEND_LO);
  assign hit_pend_hi = (a8 == OFS_PEND_HI);
  assign hit_tbl     = in_table(a8);

  pih_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (pclk),
    .rst_n (presetn),
    .d_i   (irq_src_i),
    .q_o   (req_s_w)
  );

  pih_flags #(.PULSE_MODE(PULSE_MODE)) u_flags (
    .clk       (pclk),
    .rst_n     (presetn),
    .req_s_i   (req_s_w),
    .wr_lo_i   (wr_go & hit_flag_lo),
    .wr_hi_i   (wr_go & hit_flag_hi),
    .wdata_i   (pwdata),
    .req_eff_o (req_eff_w),
    .flag_o    (flag_w)
  );

  pih_slots #(.WORDS(TBL_WORDS), .IDX_W(TIDX_W)) u_slots (
    .clk     (pclk),
    .rst_n   (presetn),
    .we_i    (wr_go & hit_tbl),
    .idx_i   (a8[TIDX_W+1:2]),
    .wdata_i (pwdata),
    .rdata_o (tbl_rd_w)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_pend
    assign pend_w[w*WORD_W +: WORD_W] =
      pend_word(en_q[w*WORD_W +: WORD_W], req_eff_w[w*WORD_W +: WORD_W]);
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      gen_q <= 1'b0;
      en_q  <= '0;
    end else if (wr_go) begin
      if (hit_ctrl)  gen_q               <= pwdata[GEN_BIT];
      if (hit_en_lo) en_q[WORD_W-1:0]    <= pwdata;
      if (hit_en_hi) en_q[NSRC-1:WORD_W] <= pwdata;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) irq_q <= 1'b0;
    else          irq_q <= gen_q & (|pend_w);
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)         rd_mux[GEN_BIT] = gen_q;
    else if (hit_en_lo)   rd_mux = en_q[WORD_W-1:0];
    else if (hit_en_hi)   rd_mux = en_q[NSRC-1:WORD_W];
    else if (hit_flag_lo) rd_mux = flag_w[WORD_W-1:0];
    else if (hit_flag_hi) rd_mux = flag_w[NSRC-1:WORD_W];
    else if (hit_pend_lo) rd_mux = pend_w[WORD_W-1:0];
    else if (hit_pend_hi) rd_mux = pend_w[NSRC-1:WORD_W];
    else if (hit_tbl)     rd_mux = tbl_rd_w;
  end

  assign prdata  = rd_mux;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq_o   = irq_q;

  // R9
  gen_off_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !gen_q |=> !irq_o);

  // R8
  irq_rise_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(irq_o) |-> ($past(gen_q) && ($past(pend_w) != '0)));

  // R10
  pend_ro_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_go && (hit_pend_lo || hit_pend_hi)) |=> ($stable(en_q) && $stable(gen_q)));

  // R3
  pend_gate_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (en_q == '0) |-> (pend_w == '0));
endmodule

// File: tb/pulse_irq_hub_tb_top.sv
module pulse_irq_hub_tb_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [63:0] src = '0;
  logic [31:0] prdata_p, prdata_l;
  logic        pready_p, pready_l, pslverr_p, pslverr_l, irq_p, irq_l;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          lvl;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t item;
  logic [31:0] got;
  logic [31:0] tbl_exp [16];

  always #10 pclk = ~pclk;

  pulse_irq_hub dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_p),
    .pready(pready_p), .pslverr(pslverr_p), .irq_src_i(src), .irq_o(irq_p));

  pulse_irq_hub #(.PULSE_MODE(1'b0)) dut_lvl_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_l),
    .pready(pready_l), .pslverr(pslverr_l), .irq_src_i(src), .irq_o(irq_l));

  // monitor: compares each read data beat against the queued expectation
  always begin
    @(negedge pclk);
    #1;
    if (psel && penable && !pwrite) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected read at %h: actual %h expected none", paddr, prdata_p);
      end else begin
        item = exp_q.pop_front();
        got = item.lvl ? prdata_l : prdata_p;
        if (got !== item.exp) begin
          mismatched++;
          $display("FAIL %s addr %h: actual %h expected %h", item.tag, paddr, got, item.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, input logic [31:0] exp,
                        input bit lvl, input string tag);
    exp_t e;
    e.exp = exp; e.lvl = lvl; e.tag = tag;
    exp_q.push_back(e);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge pclk);
    src[idx] = 1'b1;
    @(negedge pclk);
    src[idx] = 1'b0;
    repeat (4) @(negedge pclk);
  endtask

  function automatic logic [31:0] slot_word(input int w);
    logic [7:0] base;
    base = 8'(4 * w);
    return {base, base + 8'd1, base + 8'd2, base + 8'd3};
  endfunction

  initial begin
    repeat (5) @(negedge pclk);
    presetn = 1'b1;

    // R1 reset state
    apb_rd(8'h00, 32'h0, 0, "R1 ctrl");
    apb_rd(8'h10, 32'h0, 0, "R1 en lo");
    apb_rd(8'h28, 32'h0, 0, "R1 en hi");
    apb_rd(8'h08, 32'h0, 0, "R1 flag lo");
    apb_rd(8'h20, 32'h0, 0, "R1 flag hi");
    apb_rd(8'h14, 32'h0, 0, "R1 pend lo");
    apb_rd(8'h2C, 32'h0, 0, "R1 pend hi");
    apb_rd(8'h40, 32'h0, 0, "R1 tbl first");
    apb_rd(8'h7C, 32'h0, 0, "R1 tbl last");
    chk("R1 irq", {31'b0, irq_p}, 32'h0);

    // R2 control and enable storage
    apb_wr(8'h00, 32'hFFFF_FFFF);
    apb_rd(8'h00, 32'h8000_0000, 0, "R2 ctrl bit31 only");
    apb_wr(8'h10, 32'hA5A5_0F0F);
    apb_rd(8'h10, 32'hA5A5_0F0F, 0, "R2 en lo");
    apb_wr(8'h28, 32'h1234_5678);
    apb_rd(8'h28, 32'h1234_5678, 1, "R2 en hi");
    apb_wr(8'h10, 32'h0);
    apb_wr(8'h28, 32'h0);

    // R4 pulses latch in flags
    pulse(3);
    pulse(40);
    apb_rd(8'h08, 32'h0000_0008, 0, "R4 flag lo");
    apb_rd(8'h20, 32'h0000_0100, 0, "R4 flag hi");
    apb_rd(8'h14, 32'h0, 0, "R3 pend gated by enable");
    apb_rd(8'h08, 32'h0, 1, "R7 level flag lo");
    chk("R8 irq idle", {31'b0, irq_p}, 32'h0);

    // R8 registered irq
    apb_wr(8'h10, 32'h0000_0008);
    chk("R8 irq not yet", {31'b0, irq_p}, 32'h0);
    @(negedge pclk);
    chk("R8 irq one cycle later", {31'b0, irq_p}, 32'h1);
    chk("R7 level irq idle", {31'b0, irq_l}, 32'h0);
    apb_rd(8'h14, 32'h0000_0008, 0, "R3 pend lo");
    apb_wr(8'h28, 32'h0000_0100);
    apb_rd(8'h2C, 32'h0000_0100, 0, "R3 pend hi");

    // R9 global enable
    apb_wr(8'h00, 32'h0);
    chk("R9 irq before edge", {31'b0, irq_p}, 32'h1);
    @(negedge pclk);
    chk("R9 irq off", {31'b0, irq_p}, 32'h0);
    apb_wr(8'h00, 32'h8000_0000);
    @(negedge pclk);
    chk("R8 irq back on", {31'b0, irq_p}, 32'h1);

    // R10 pending read-only
    apb_wr(8'h14, 32'h0);
    apb_wr(8'h2C, 32'hFFFF_FFFF);
    apb_rd(8'h14, 32'h0000_0008, 0, "R10 pend lo kept");
    apb_rd(8'h2C, 32'h0000_0100, 0, "R10 pend hi kept");
    apb_rd(8'h10, 32'h0000_0008, 0, "R10 en lo kept");
    apb_rd(8'h00, 32'h8000_0000, 0, "R10 ctrl kept");

    // R5 clear by writing 0
    apb_wr(8'h08, 32'hFFFF_FFFF);
    apb_rd(8'h08, 32'h0000_0008, 0, "R5 ones keep");
    apb_wr(8'h08, 32'hFFFF_FFF7);
    apb_rd(8'h08, 32'h0, 0, "R5 bit3 cleared");
    chk("R8 irq from hi word", {31'b0, irq_p}, 32'h1);
    apb_wr(8'h20, 32'h0);
    @(negedge pclk);
    chk("R5 irq after hi clear", {31'b0, irq_p}, 32'h0);
    apb_rd(8'h20, 32'h0, 0, "R5 flag hi cleared");

    // R6 edge beats clear in the same cycle
    pulse(7);
    apb_rd(8'h08, 32'h0000_0080, 0, "R6 pre flag");
    @(negedge pclk);
    src[5] = 1'b1;
    apb_wr(8'h08, 32'h0);
    apb_rd(8'h08, 32'h0000_0020, 0, "R6 set wins, other cleared");
    src[5] = 1'b0;

    // R11 unmapped and response pins
    apb_rd(8'h04, 32'h0, 0, "R11 unmapped 04");
    apb_rd(8'h30, 32'h0, 0, "R11 unmapped 30");
    apb_rd(8'h80, 32'h0, 0, "R11 unmapped 80");
    apb_rd(8'hFC, 32'h0, 1, "R11 unmapped FC");
    chk("R11 pready", {30'b0, pready_p, pready_l}, 32'h3);
    chk("R11 pslverr", {30'b0, pslverr_p, pslverr_l}, 32'h0);

    // R12 slot table
    for (int w = 0; w < 16; w++) begin
      tbl_exp[w] = slot_word(w);
      apb_wr(8'(8'h40 + 4 * w), tbl_exp[w]);
    end
    tbl_exp[5] = 32'hDEAD_BEEF;
    apb_wr(8'h54, 32'hDEAD_BEEF);
    for (int w = 0; w < 16; w++)
      apb_rd(8'(8'h40 + 4 * w), tbl_exp[w], (w % 2) == 1, "R12 slot word");

    // R7 level mode follows the input
    apb_wr(8'h10, 32'h0000_0400);
    @(negedge pclk);
    src[10] = 1'b1;
    repeat (4) @(negedge pclk);
    apb_rd(8'h14, 32'h0000_0400, 1, "R7 level pend high");
    chk("R7 level irq", {31'b0, irq_l}, 32'h1);
    src[10] = 1'b0;
    repeat (4) @(negedge pclk);
    apb_rd(8'h14, 32'h0, 1, "R7 level pend follows low");
    apb_rd(8'h14, 32'h0000_0400, 0, "R4 pulse pend held");
    apb_rd(8'h08, 32'h0, 1, "R7 level flag reads 0");
    chk("R7 level irq low", {31'b0, irq_l}, 32'h0);

    repeat (3) @(negedge pclk);
    if (exp_q.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL monitor: actual %0d reads left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule